// File: doc/BRIEF.md
# I2C Four-Byte Configuration Target

This block is a target-only I2C port that lets a bus controller load or read back a fixed 32-bit configuration word. The word is split into four bytes, and every transaction carries all four. SCL and SDA come in as raw pad samples. They are synchronized to a fast system clock, which must run at least eight times the SCL rate. The block drives SDA only as an open-drain pull-down enable, and it never touches SCL.

A write is a START, the address byte with the R/W bit low, four data bytes and a STOP. The incoming bytes collect in a shadow store. The active configuration outputs take all four bytes at once, and only when the STOP arrives after a complete set. A read is a START, the address byte with the R/W bit high, and then four bytes shifted out from the active word. The controller acknowledges each byte except the last. There is no register pointer, so every access covers the whole word.

Top module: `i2c_cfg_port`

## Requirements
- R1: After reset, `cfgOut` equals the parameter `CFG_DEFAULT` and `sdaPullDown` is 0.
- R2: The first byte after START is received most significant bit first. Bits 7..1 are compared with `DEV_ADDR`, and bit 0 selects a read (1) or a write (0). On a match, the target pulls SDA low through the ninth clock of that byte.
- R3: On an address mismatch, the target does not acknowledge and drives nothing until the next START. Data sent in that transaction leaves `cfgOut` unchanged.
- R4: In a write, the target acknowledges each of the four data bytes. Byte 0 lands in `cfgOut[7:0]` and byte 3 in `cfgOut[31:24]`.
- R5: `cfgOut` keeps its old value until STOP. At the STOP that follows four complete data bytes, all four bytes appear on `cfgOut` together.
- R6: A STOP or a repeated START that arrives before the fourth data byte is complete discards the partial write, and `cfgOut` is unchanged.
- R7: A read returns active bytes 0, 1, 2 and 3 in that order, each most significant bit first. After the final byte, the target releases SDA.
- R8: If the controller does not acknowledge a read byte before byte 3, the target stops sending and releases SDA.
- R9: `sdaPullDown` never changes while SCL is high.
- R10: The cycle after a STOP is detected, `sdaPullDown` is 0.
- R11: Data bytes beyond the fourth in a write are not acknowledged and do not alter the value that the STOP commits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sampled SCL pad level |
| sdaIn | input | 1 | Sampled SDA pad level (wired-AND bus value) |
| sdaPullDown | output | 1 | When 1, the SDA pad is pulled low; when 0, the pad is released |
| cfgOut | output | 32 | Active configuration word, byte 0 in the low bits |

## Verification
The in-line properties check the timing rules on every cycle. The SDA pull-down may change only after a synchronized SCL fall, START or STOP, and it stays put while SCL remains high. It is released right after any STOP. The configuration word changes only in the cycle after a STOP. Only the bench's bus scenarios can show the content of the word. Those scenarios cover which bytes are acknowledged, the byte order on reads, and how partial writes, repeated STARTs, extra bytes, foreign addresses and an early controller NACK are handled.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

  // Synchronized bus view and detected bus events
  typedef struct packed {
    logic scl;
    logic sda;
    logic sclRise;
    logic sclFall;
    logic start;
    logic stop;
  } busEvt_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       shiftIn;
    logic       capture;
    logic       commit;
    logic       loadTx;
    logic       shiftTx;
    logic [7:0] byteSel;
  } dpCtl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_WR_DONE,
    ST_RD,
    ST_RD_ACK
  } ctlState_t;

endpackage

// File: rtl/i2c_cfg_sync.sv
module i2c_cfg_sync
  import i2c_cfg_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclIn,
  input  logic    sdaIn,
  output busEvt_t evt
);

  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic              sclPrev;
  logic              sdaPrev;

  // idle bus level is high on both lines
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  always_comb begin
    evt.scl     = sclPipe[STAGES-1];
    evt.sda     = sdaPipe[STAGES-1];
    evt.sclRise = evt.scl & ~sclPrev;
    evt.sclFall = ~evt.scl & sclPrev;
    evt.start   = evt.scl & sclPrev & sdaPrev & ~evt.sda;
    evt.stop    = evt.scl & sclPrev & ~sdaPrev & evt.sda;
  end

endmodule

// File: rtl/i2c_cfg_ctrl.sv
module i2c_cfg_ctrl
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h2C,
  parameter int         NUM_BYTES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  busEvt_t    evt,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output dpCtl_t     ctl,
  output logic       sdaPullDown
);

  localparam int IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES - 1);

  ctlState_t        state;
  logic [3:0]       bitCnt;
  logic [IDX_W-1:0] byteIdx;
  logic             isRead;
  logic             masterAck;
  logic             byteDone;

  assign byteDone = (bitCnt == 4'd8);

  // strobes to datapath
  always_comb begin
    ctl         = '0;
    ctl.byteSel = 8'(byteIdx);
    ctl.commit  = evt.stop && (state == ST_WR_DONE);
    unique case (state)
      ST_ADDR:     ctl.shiftIn = evt.sclRise && !byteDone;
      ST_WR: begin
        ctl.shiftIn = evt.sclRise && !byteDone;
        ctl.capture = evt.sclFall && byteDone;
      end
      ST_ADDR_ACK: ctl.loadTx = evt.sclFall && isRead;
      ST_RD:       ctl.shiftTx = evt.sclFall && !byteDone;
      ST_RD_ACK: begin
        ctl.loadTx  = evt.sclFall && masterAck && (byteIdx != LAST_IDX);
        ctl.byteSel = 8'(byteIdx) + 8'd1;
      end
      default: ;
    endcase
  end

  assign sdaPullDown = (state == ST_ADDR_ACK) || (state == ST_WR_ACK) ||
                       ((state == ST_RD) && !txBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      byteIdx   <= '0;
      isRead    <= 1'b0;
      masterAck <= 1'b0;
    end else if (evt.start) begin
      state   <= ST_ADDR;
      bitCnt  <= '0;
      byteIdx <= '0;
    end else if (evt.stop) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (evt.sclRise && !byteDone) bitCnt <= bitCnt + 4'd1;
          if (evt.sclFall && byteDone) begin
            if (rxByte[7:1] == DEV_ADDR) begin
              state  <= ST_ADDR_ACK;
              isRead <= rxByte[0];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: if (evt.sclFall) begin
          bitCnt <= '0;
          state  <= isRead ? ST_RD : ST_WR;
        end
        ST_WR: begin
          if (evt.sclRise && !byteDone) bitCnt <= bitCnt + 4'd1;
          if (evt.sclFall && byteDone) state <= ST_WR_ACK;
        end
        ST_WR_ACK: if (evt.sclFall) begin
          bitCnt <= '0;
          if (byteIdx == LAST_IDX) begin
            state <= ST_WR_DONE;
          end else begin
            byteIdx <= byteIdx + IDX_W'(1);
            state   <= ST_WR;
          end
        end
        ST_RD: begin
          if (evt.sclRise && !byteDone) bitCnt <= bitCnt + 4'd1;
          if (evt.sclFall && byteDone) state <= ST_RD_ACK;
        end
        ST_RD_ACK: begin
          if (evt.sclRise) masterAck <= ~evt.sda;
          if (evt.sclFall) begin
            if (masterAck && (byteIdx != LAST_IDX)) begin
              byteIdx <= byteIdx + IDX_W'(1);
              bitCnt  <= '0;
              state   <= ST_RD;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R9
  pd_stable_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evt.scl && $past(evt.scl)) |-> $stable(sdaPullDown));

  // R9
  pd_change_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullDown) |-> $past(evt.sclFall || evt.start || evt.stop));

endmodule

// File: rtl/i2c_cfg_data.sv
module i2c_cfg_data
  import i2c_cfg_pkg::*;
#(
  parameter int                     NUM_BYTES   = 4,
  parameter logic [NUM_BYTES*8-1:0] CFG_DEFAULT = '0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpCtl_t                 ctl,
  input  logic                   sdaBit,
  output logic [7:0]             rxByte,
  output logic                   txBit,
  output logic [NUM_BYTES*8-1:0] cfgOut
);

  localparam int IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

  logic [7:0]       rxShift;
  logic [7:0]       txShift;
  logic [7:0]       shadowB [NUM_BYTES];
  logic [7:0]       activeB [NUM_BYTES];
  logic [IDX_W-1:0] sel;

  assign sel    = ctl.byteSel[IDX_W-1:0];
  assign rxByte = rxShift;
  assign txBit  = txShift[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '1;
    end else begin
      if (ctl.shiftIn) rxShift <= {rxShift[6:0], sdaBit};
      if (ctl.loadTx)       txShift <= activeB[sel];
      else if (ctl.shiftTx) txShift <= {txShift[6:0], 1'b1};
    end
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : gByte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shadowB[g] <= '0;
        activeB[g] <= CFG_DEFAULT[g*8 +: 8];
      end else begin
        if (ctl.capture && (sel == IDX_W'(g))) shadowB[g] <= rxShift;
        if (ctl.commit) activeB[g] <= shadowB[g];
      end
    end
    assign cfgOut[g*8 +: 8] = activeB[g];
  end

endmodule

// File: rtl/i2c_cfg_port.sv
module i2c_cfg_port
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h2C,
  parameter logic [31:0] CFG_DEFAULT = 32'hA5C3_0F81,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sdaPullDown,
  output logic [31:0] cfgOut
);

  localparam int NUM_BYTES = 4;

  busEvt_t    evt;
  dpCtl_t     ctl;
  logic [7:0] rxByte;
  logic       txBit;

  i2c_cfg_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .evt(evt)
  );

  i2c_cfg_ctrl #(.DEV_ADDR(DEV_ADDR), .NUM_BYTES(NUM_BYTES)) uCtrl (
    .clk(clk), .rstN(rstN), .evt(evt), .rxByte(rxByte), .txBit(txBit),
    .ctl(ctl), .sdaPullDown(sdaPullDown)
  );

  i2c_cfg_data #(.NUM_BYTES(NUM_BYTES), .CFG_DEFAULT(CFG_DEFAULT)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdaBit(evt.sda),
    .rxByte(rxByte), .txBit(txBit), .cfgOut(cfgOut)
  );

  // R5
  cfg_only_on_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgOut) |-> $past(evt.stop));

  // R10
  release_after_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.stop |=> !sdaPullDown);

endmodule

// File: tb/i2c_cfg_port_test.sv
module i2c_cfg_port_test;

  localparam int          CLK_PERIOD = 10;
  localparam int          H = 8;
  localparam int          Q = 4;
  localparam logic [6:0]  ADDR = 7'h2C;
  localparam logic [31:0] DEF  = 32'hA5C3_0F81;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclM = 1'b1;
  logic        sdaM = 1'b1;
  logic        pd;
  logic [31:0] cfg;
  logic        sdaLine;

  assign sdaLine = sdaM & ~pd;

  i2c_cfg_port #(.DEV_ADDR(ADDR), .CFG_DEFAULT(DEF)) uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaPullDown(pd), .cfgOut(cfg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // scoreboard
  typedef struct {
    string       tag;
    logic [31:0] val;
  } item_t;

  item_t       expQ[$];
  logic [31:0] actQ[$];
  int          total = 0;
  int          bad = 0;
  bit          finished = 0;
  item_t       curE;
  logic [31:0] curA;

  task automatic check(input string tag, input logic [31:0] e, input logic [31:0] a);
    item_t it;
    it.tag = tag;
    it.val = e;
    expQ.push_back(it);
    actQ.push_back(a);
  endtask

  always @(negedge clk) begin
    if (expQ.size() > 0 && actQ.size() > 0) begin
      curE = expQ.pop_front();
      curA = actQ.pop_front();
      total++;
      if (curE.val !== curA) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", curE.tag, curA, curE.val);
      end
    end
  end

  // R9 monitor: pull-down must not move while SCL is high
  int   viol = 0;
  logic pdPrev = 1'b0;
  logic sclPrev = 1'b1;
  always @(negedge clk) begin
    if (rstN && sclM && sclPrev && (pd !== pdPrev)) viol++;
    pdPrev  = pd;
    sclPrev = sclM;
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitClk(Q);
    sclM = 1'b1; waitClk(H);
    sdaM = 1'b0; waitClk(H);
    sclM = 1'b0; waitClk(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitClk(Q);
    sclM = 1'b1; waitClk(H);
    sdaM = 1'b1; waitClk(H);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; waitClk(Q);
    sclM = 1'b1; waitClk(H);
    sclM = 1'b0; waitClk(Q);
  endtask

  task automatic recvBit(output logic b);
    sdaM = 1'b1; waitClk(Q);
    sclM = 1'b1; waitClk(H/2);
    b = sdaLine; waitClk(H/2);
    sclM = 1'b0; waitClk(Q);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ackd);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(b);
    ackd = ~b;
  endtask

  task automatic recvByte(output logic [7:0] v, input logic giveAck);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recvBit(b);
      v[i] = b;
    end
    sendBit(~giveAck);
  endtask

  task automatic writeBytes(input string tag, input logic [31:0] w, input logic expAck);
    logic a;
    for (int i = 0; i < 4; i++) begin
      sendByte(w[i*8 +: 8], a);
      check(tag, 32'(expAck), 32'(a));
    end
  endtask

  task automatic readWord(input string tag, input logic [31:0] e);
    logic [7:0] v;
    for (int i = 0; i < 4; i++) begin
      recvByte(v, i < 3);
      check(tag, 32'(e[i*8 +: 8]), 32'(v));
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    logic a;
    logic [7:0] v;
    waitClk(5);
    rstN = 1'b1;
    waitClk(3);
    check("R1 cfg after reset", DEF, cfg);
    check("R1 pulldown after reset", 32'd0, 32'(pd));

    // full write
    busStart();
    sendByte({ADDR, 1'b0}, a);
    check("R2 write address ack", 32'd1, 32'(a));
    writeBytes("R4 data byte ack", 32'h4433_2211, 1'b1);
    check("R5 cfg held before STOP", DEF, cfg);
    busStop();
    waitClk(4);
    check("R5 cfg committed at STOP", 32'h4433_2211, cfg);
    check("R10 pulldown released after STOP", 32'd0, 32'(pd));

    // full read
    busStart();
    sendByte({ADDR, 1'b1}, a);
    check("R2 read address ack", 32'd1, 32'(a));
    readWord("R7 read byte", 32'h4433_2211);
    check("R7 SDA released after last byte", 32'd0, 32'(pd));
    busStop();

    // foreign address, write then read
    busStart();
    sendByte({ADDR ^ 7'h01, 1'b0}, a);
    check("R3 foreign address nack", 32'd0, 32'(a));
    writeBytes("R3 foreign data nack", 32'h0BAD_F00D, 1'b0);
    busStop();
    waitClk(4);
    check("R3 cfg unchanged", 32'h4433_2211, cfg);
    busStart();
    sendByte({ADDR ^ 7'h40, 1'b1}, a);
    check("R3 foreign read nack", 32'd0, 32'(a));
    recvByte(v, 1'b0);
    check("R3 foreign read silent", 32'hFF, 32'(v));
    busStop();

    // partial write then STOP
    busStart();
    sendByte({ADDR, 1'b0}, a);
    sendByte(8'h99, a);
    sendByte(8'h88, a);
    busStop();
    waitClk(4);
    check("R6 partial write then STOP", 32'h4433_2211, cfg);

    // partial write then repeated START, then full write
    busStart();
    sendByte({ADDR, 1'b0}, a);
    sendByte(8'h77, a);
    busStart();
    waitClk(2);
    check("R6 cfg after repeated START", 32'h4433_2211, cfg);
    sendByte({ADDR, 1'b0}, a);
    check("R6 ack after repeated START", 32'd1, 32'(a));
    writeBytes("R4 data ack after restart", 32'hDEAD_BEEF, 1'b1);
    busStop();
    waitClk(4);
    check("R6 only full write committed", 32'hDEAD_BEEF, cfg);

    // fifth byte
    busStart();
    sendByte({ADDR, 1'b0}, a);
    writeBytes("R11 first four acked", 32'h0403_0201, 1'b1);
    sendByte(8'h55, a);
    check("R11 fifth byte nack", 32'd0, 32'(a));
    busStop();
    waitClk(4);
    check("R11 fifth byte ignored", 32'h0403_0201, cfg);

    // early NACK read
    busStart();
    sendByte({ADDR, 1'b1}, a);
    recvByte(v, 1'b0);
    check("R8 first byte value", 32'h01, 32'(v));
    check("R8 SDA released after early NACK", 32'd0, 32'(pd));
    recvBit(a);
    check("R8 bus stays high", 32'd1, 32'(a));
    busStop();
    busStart();
    sendByte({ADDR, 1'b1}, a);
    readWord("R7 read after early NACK", 32'h0403_0201);
    busStop();
    waitClk(4);

    check("R9 pulldown stable while SCL high", 32'd0, 32'(viol));

    while (expQ.size() > 0) waitClk(1);
    waitClk(2);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule